// File: doc/BRIEF.md
# Host Command Stream Decoder

This block takes a stream of 32-bit command words over a valid/ready input and interprets them as a small command language. Every word that arrives while the decoder is idle is a header. The header's top four bits select the operation. Some operations are followed by data words or address words. The decoder counts those words and then goes back to expecting a header. Each data word is turned into a register-write transaction. The transaction carries the current class, a register offset and the word itself. The offset advances in one of three ways: it rises by one per word, it stays fixed, or it steps through the set bits of a mask.

Other operations are reported on single-cycle strobes of their own. These are immediate writes, restart targets, gather requests (the address words are collected first), lock acquire and release, unknown extend sub-operations and undefined opcodes. The decoder also remembers state between commands: the current class, a payload count used by the wide write commands, a stream identifier and an application identifier. A consumer that stalls the write output pushes back on the input.

The control path is a four-state machine:
- `S_HDR` waits for a header.
- `S_DATA` consumes data words.
- `S_ADDR0` and `S_ADDR1` collect the gather address words.

The transitions are:
- `HDR_TO_DATA`: a write-type header with a nonzero word count.
- `HDR_TO_ADDR`: any gather header.
- `DATA_TO_HDR`: the last data word is accepted.
- `ADDR0_TO_ADDR1`: the first address word of a wide gather.
- `ADDR_TO_HDR`: the final address word is accepted.

Every other accepted header leaves the machine in `S_HDR`.

Top module: `cmd_stream_decoder`

## Requirements
- R1: Synchronous active-high reset clears the class, the stream id and the app id to zero, marks the payload count invalid, deasserts every output strobe and `wr_valid`, and returns to `S_HDR` with `in_ready` high.
- R2: Opcode 0 loads the class from bits 15:6. If its 6-bit mask (bits 5:0) is nonzero, popcount(mask) data words follow, written to the offset in bits 27:16 plus the position of each set mask bit, lowest bit first. A zero mask means the next word is a header.
- R3: Opcode 1 takes its offset from bits 27:16 and its word count from bits 15:0. Each data word is written to the current offset, and the offset then rises by one. A count of zero means the next word is a header.
- R4: Opcode 2 behaves like R3 except that every data word goes to the same offset.
- R5: Opcode 3 carries a 16-bit mask in bits 15:0. popcount(mask) data words follow, each written to the offset from bits 27:16 plus the index of the next set mask bit, taken from the lowest bit upward.
- R6: Opcode 4 pulses `imm_valid` for one cycle with `imm_offset` = bits 27:16 and `imm_data` = bits 15:0. No data words follow.
- R7: Opcode 5 pulses `restart_valid` with `restart_addr` equal to the header shifted left by 4 (low 32 bits kept).
- R8: Opcode 6 is followed by one address word. Opcode 12 is followed by two address words, low half first. After the last address word, `gather_valid` pulses with:
    - `gather_offset` = bits 27:16 (opcode 6 only);
    - `gather_insert` = bit 15 and `gather_type` = bit 14 (opcode 6 only);
    - `gather_count` = bits 13:0;
    - `gather_wide` set for opcode 12;
    - the collected address on `gather_addr`.
- R9: Opcode 9 latches bits 15:0 as the payload count. Opcodes 10 (incrementing) and 11 (fixed offset) take their offset from bits 21:0 and use the payload count as their word count. They have no data words while the payload is invalid or zero. The payload count is kept across commands.
- R10: Opcode 14 reads a sub-operation from bits 27:24 and an index from bits 7:0. Sub-operation 0 pulses `lock_acq`, 1 pulses `lock_rel` (both with `lock_index`), and any other value pulses `ext_unknown`.
- R11: Opcode 7 latches bits 21:0 onto `stream_id`. Opcode 8 latches bits 7:0 onto `app_id`.
- R12: Opcodes 13 and 15 pulse `op_err` for one cycle. The word is consumed as a header with no data words.
- R13: While `wr_valid` is high and `wr_ready` is low, `in_ready` is low and the write output holds its class, offset and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word present |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted this cycle when valid |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Write consumer ready |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 22 | Register offset of the write |
| wr_data | output | 32 | Write data |
| imm_valid | output | 1 | Immediate write strobe |
| imm_offset | output | 12 | Immediate write offset |
| imm_data | output | 16 | Immediate write data |
| restart_valid | output | 1 | Restart strobe |
| restart_addr | output | 32 | Restart target address |
| gather_valid | output | 1 | Gather request strobe |
| gather_wide | output | 1 | Gather used two address words |
| gather_insert | output | 1 | Gather insert flag |
| gather_type | output | 1 | Gather type flag |
| gather_offset | output | 12 | Gather register offset |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 64 | Gather address (upper half zero for one-word form) |
| lock_acq | output | 1 | Lock acquire strobe |
| lock_rel | output | 1 | Lock release strobe |
| ext_unknown | output | 1 | Unknown extend sub-operation strobe |
| lock_index | output | 8 | Lock index |
| op_err | output | 1 | Undefined opcode strobe |
| stream_id | output | 22 | Latched stream identifier |
| app_id | output | 8 | Latched application identifier |

## Verification
The properties assume that `in_valid`, `in_word` and `wr_ready` are settled values that change only away from the rising edge, and that the input is idle during reset. The properties on the strobes compare each pulse with the word accepted one cycle earlier, so they rely on one word being transferred per accepted handshake. The stimulus drives every input on the falling edge and holds `in_valid` low around reset. It keeps `wr_ready` high except in the one directed stall test, so that in the vector table every word is accepted in the cycle it is presented.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    localparam int WORD_W  = 32;
    localparam int CLASS_W = 10;
    localparam int OFS_W   = 22;
    localparam int CNT_W   = 16;
    localparam int MASK_W  = 16;
    localparam int NOFS_W  = 12;

    typedef enum logic [3:0] {
        OP_CLASS    = 4'h0,
        OP_INCR     = 4'h1,
        OP_FIXED    = 4'h2,
        OP_MASKED   = 4'h3,
        OP_IMM      = 4'h4,
        OP_RESTART  = 4'h5,
        OP_GATHER   = 4'h6,
        OP_STREAM   = 4'h7,
        OP_APP      = 4'h8,
        OP_PAYLOAD  = 4'h9,
        OP_WINCR    = 4'hA,
        OP_WFIXED   = 4'hB,
        OP_WGATHER  = 4'hC,
        OP_EXTEND   = 4'hE
    } opcode_e;

    typedef enum logic [3:0] {
        H_CLASS, H_WRITE, H_IMM, H_RESTART, H_GATHER, H_STREAM, H_APP,
        H_PAYLOAD, H_ACQ, H_REL, H_XUNK, H_BAD
    } hkind_e;

    typedef enum logic [1:0] {
        M_INC, M_FIXED, M_MASK
    } wmode_e;

    typedef enum logic [1:0] {
        S_HDR, S_DATA, S_ADDR0, S_ADDR1
    } state_e;

    typedef struct packed {
        hkind_e               kind;
        wmode_e               mode;
        logic [OFS_W-1:0]     offset;
        logic [CNT_W-1:0]     count;
        logic [MASK_W-1:0]    mask;
        logic [CLASS_W-1:0]   klass;
        logic                 wide;
    } hdr_t;

    function automatic logic [CNT_W-1:0] popcnt(input logic [MASK_W-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) begin
            n = n + {{(CNT_W-1){1'b0}}, m[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
    import cmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  payload,
    input  logic              payload_ok,
    output hdr_t              hdr
);
    localparam int CLS_LO = 6;

    logic [MASK_W-1:0] cls_mask;
    logic [MASK_W-1:0] wr_mask;

    assign cls_mask = {{(MASK_W-6){1'b0}}, word[5:0]};
    assign wr_mask  = word[MASK_W-1:0];

    always_comb begin
        hdr        = '0;
        hdr.kind   = H_BAD;
        hdr.mode   = M_INC;
        hdr.offset = {{(OFS_W-NOFS_W){1'b0}}, word[27:16]};
        hdr.klass  = word[CLS_LO+CLASS_W-1:CLS_LO];
        unique case (word[31:28])
            OP_CLASS: begin
                hdr.kind  = H_CLASS;
                hdr.mode  = M_MASK;
                hdr.mask  = cls_mask;
                hdr.count = popcnt(cls_mask);
            end
            OP_INCR: begin
                hdr.kind  = H_WRITE;
                hdr.mode  = M_INC;
                hdr.count = word[CNT_W-1:0];
            end
            OP_FIXED: begin
                hdr.kind  = H_WRITE;
                hdr.mode  = M_FIXED;
                hdr.count = word[CNT_W-1:0];
            end
            OP_MASKED: begin
                hdr.kind  = H_WRITE;
                hdr.mode  = M_MASK;
                hdr.mask  = wr_mask;
                hdr.count = popcnt(wr_mask);
            end
            OP_IMM:     hdr.kind = H_IMM;
            OP_RESTART: hdr.kind = H_RESTART;
            OP_GATHER:  hdr.kind = H_GATHER;
            OP_STREAM:  hdr.kind = H_STREAM;
            OP_APP:     hdr.kind = H_APP;
            OP_PAYLOAD: hdr.kind = H_PAYLOAD;
            OP_WINCR, OP_WFIXED: begin
                hdr.kind   = H_WRITE;
                hdr.mode   = (word[31:28] == OP_WINCR) ? M_INC : M_FIXED;
                hdr.offset = word[OFS_W-1:0];
                hdr.count  = payload_ok ? payload : '0;
            end
            OP_WGATHER: begin
                hdr.kind = H_GATHER;
                hdr.wide = 1'b1;
            end
            OP_EXTEND: begin
                unique case (word[27:24])
                    4'h0:    hdr.kind = H_ACQ;
                    4'h1:    hdr.kind = H_REL;
                    default: hdr.kind = H_XUNK;
                endcase
            end
            default: hdr.kind = H_BAD;
        endcase
    end
endmodule

// File: rtl/cmd_mask_pick.sv
module cmd_mask_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0]         mask,
    output logic [$clog2(W)-1:0] pos,
    output logic [W-1:0]         rest
);
    localparam int PW = $clog2(W);

    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) pos = PW'(i);
        end
    end

    assign rest = mask & (mask - {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [31:0]  in_word,
    output logic         in_ready,
    output logic         wr_valid,
    input  logic         wr_ready,
    output logic [9:0]   wr_class,
    output logic [21:0]  wr_offset,
    output logic [31:0]  wr_data,
    output logic         imm_valid,
    output logic [11:0]  imm_offset,
    output logic [15:0]  imm_data,
    output logic         restart_valid,
    output logic [31:0]  restart_addr,
    output logic         gather_valid,
    output logic         gather_wide,
    output logic         gather_insert,
    output logic         gather_type,
    output logic [11:0]  gather_offset,
    output logic [13:0]  gather_count,
    output logic [63:0]  gather_addr,
    output logic         lock_acq,
    output logic         lock_rel,
    output logic         ext_unknown,
    output logic [7:0]   lock_index,
    output logic         op_err,
    output logic [21:0]  stream_id,
    output logic [7:0]   app_id
);
    localparam int PW = $clog2(MASK_W);

    state_e               state, state_nxt;
    hdr_t                 hdr;
    logic                 acc;
    logic [CNT_W-1:0]     payload_q;
    logic                 payload_ok_q;
    logic [CLASS_W-1:0]   cls_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [OFS_W-1:0]     ofs_q;
    logic [MASK_W-1:0]    mask_q;
    wmode_e               mode_q;
    logic [PW-1:0]        pick_pos;
    logic [MASK_W-1:0]    pick_rest;

    assign in_ready = !(wr_valid && !wr_ready);
    assign acc      = in_valid && in_ready;

    cmd_hdr_decode u_dec (
        .word       (in_word),
        .payload    (payload_q),
        .payload_ok (payload_ok_q),
        .hdr        (hdr)
    );

    cmd_mask_pick #(.W(MASK_W)) u_pick (
        .mask (mask_q),
        .pos  (pick_pos),
        .rest (pick_rest)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= S_HDR;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_HDR: begin
                if (acc) begin
                    if ((hdr.kind == H_CLASS || hdr.kind == H_WRITE) && hdr.count != '0)
                        state_nxt = S_DATA;
                    else if (hdr.kind == H_GATHER)
                        state_nxt = S_ADDR0;
                end
            end
            S_DATA:  if (acc && cnt_q == CNT_W'(1)) state_nxt = S_HDR;
            S_ADDR0: if (acc) state_nxt = gather_wide ? S_ADDR1 : S_HDR;
            S_ADDR1: if (acc) state_nxt = S_HDR;
            default: state_nxt = S_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            payload_q     <= '0;
            payload_ok_q  <= 1'b0;
            cls_q         <= '0;
            cnt_q         <= '0;
            ofs_q         <= '0;
            mask_q        <= '0;
            mode_q        <= M_INC;
            wr_valid      <= 1'b0;
            wr_class      <= '0;
            wr_offset     <= '0;
            wr_data       <= '0;
            imm_valid     <= 1'b0;
            imm_offset    <= '0;
            imm_data      <= '0;
            restart_valid <= 1'b0;
            restart_addr  <= '0;
            gather_valid  <= 1'b0;
            gather_wide   <= 1'b0;
            gather_insert <= 1'b0;
            gather_type   <= 1'b0;
            gather_offset <= '0;
            gather_count  <= '0;
            gather_addr   <= '0;
            lock_acq      <= 1'b0;
            lock_rel      <= 1'b0;
            ext_unknown   <= 1'b0;
            lock_index    <= '0;
            op_err        <= 1'b0;
            stream_id     <= '0;
            app_id        <= '0;
        end else begin
            imm_valid     <= 1'b0;
            restart_valid <= 1'b0;
            gather_valid  <= 1'b0;
            lock_acq      <= 1'b0;
            lock_rel      <= 1'b0;
            ext_unknown   <= 1'b0;
            op_err        <= 1'b0;
            if (wr_valid && wr_ready) wr_valid <= 1'b0;

            if (acc) begin
                unique case (state)
                    S_HDR: begin
                        unique case (hdr.kind)
                            H_CLASS, H_WRITE: begin
                                if (hdr.kind == H_CLASS) cls_q <= hdr.klass;
                                cnt_q  <= hdr.count;
                                ofs_q  <= hdr.offset;
                                mask_q <= hdr.mask;
                                mode_q <= hdr.mode;
                            end
                            H_IMM: begin
                                imm_valid  <= 1'b1;
                                imm_offset <= in_word[27:16];
                                imm_data   <= in_word[15:0];
                            end
                            H_RESTART: begin
                                restart_valid <= 1'b1;
                                restart_addr  <= {in_word[27:0], 4'h0};
                            end
                            H_GATHER: begin
                                gather_wide   <= hdr.wide;
                                gather_insert <= hdr.wide ? 1'b0 : in_word[15];
                                gather_type   <= hdr.wide ? 1'b0 : in_word[14];
                                gather_offset <= hdr.wide ? '0 : in_word[27:16];
                                gather_count  <= in_word[13:0];
                                gather_addr   <= '0;
                            end
                            H_STREAM:  stream_id <= in_word[21:0];
                            H_APP:     app_id    <= in_word[7:0];
                            H_PAYLOAD: begin
                                payload_q    <= in_word[CNT_W-1:0];
                                payload_ok_q <= 1'b1;
                            end
                            H_ACQ: begin
                                lock_acq   <= 1'b1;
                                lock_index <= in_word[7:0];
                            end
                            H_REL: begin
                                lock_rel   <= 1'b1;
                                lock_index <= in_word[7:0];
                            end
                            H_XUNK: ext_unknown <= 1'b1;
                            default: op_err <= 1'b1;
                        endcase
                    end
                    S_DATA: begin
                        wr_valid <= 1'b1;
                        wr_data  <= in_word;
                        wr_class <= cls_q;
                        cnt_q    <= cnt_q - CNT_W'(1);
                        if (mode_q == M_MASK) begin
                            wr_offset <= ofs_q + OFS_W'(pick_pos);
                            mask_q    <= pick_rest;
                        end else begin
                            wr_offset <= ofs_q;
                        end
                        if (mode_q == M_INC) ofs_q <= ofs_q + OFS_W'(1);
                    end
                    S_ADDR0: begin
                        gather_addr[31:0] <= in_word;
                        if (!gather_wide) gather_valid <= 1'b1;
                    end
                    S_ADDR1: begin
                        gather_addr[63:32] <= in_word;
                        gather_valid       <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        in_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [9:0]  wr_class,
    input logic [21:0] wr_offset,
    input logic [31:0] wr_data,
    input logic        imm_valid,
    input logic [11:0] imm_offset,
    input logic [15:0] imm_data,
    input logic        restart_valid,
    input logic [31:0] restart_addr,
    input logic        gather_valid,
    input logic        lock_acq,
    input logic        lock_rel,
    input logic        ext_unknown,
    input logic        op_err
);
    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)
                                     && $stable(wr_offset) && $stable(wr_class)));

    // R3
    write_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(in_valid && in_ready) && wr_data == $past(in_word));

    // R6
    imm_src_chk: assert property (@(posedge clk) disable iff (rst)
        imm_valid |-> ($past(in_valid && in_ready) && $past(in_word[31:28]) == 4'h4
                       && imm_data == $past(in_word[15:0])
                       && imm_offset == $past(in_word[27:16])));

    // R7
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        restart_valid |-> ($past(in_valid && in_ready)
                           && restart_addr == ($past(in_word) << 4)));

    // R12
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        op_err |-> ($past(in_valid && in_ready)
                    && ($past(in_word[31:28]) == 4'hD || $past(in_word[31:28]) == 4'hF)));

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({imm_valid, restart_valid, gather_valid, lock_acq, lock_rel,
                  ext_unknown, op_err}));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk u_chk (.*);

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [21:0] wr_offset;
    logic [31:0] wr_data;
    logic        imm_valid;
    logic [11:0] imm_offset;
    logic [15:0] imm_data;
    logic        restart_valid;
    logic [31:0] restart_addr;
    logic        gather_valid, gather_wide, gather_insert, gather_type;
    logic [11:0] gather_offset;
    logic [13:0] gather_count;
    logic [63:0] gather_addr;
    logic        lock_acq, lock_rel, ext_unknown;
    logic [7:0]  lock_index;
    logic        op_err;
    logic [21:0] stream_id;
    logic [7:0]  app_id;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (.*);

    localparam logic [3:0] K_NONE = 4'd0, K_WR = 4'd1, K_IMM = 4'd2, K_RST = 4'd3,
                           K_GTH = 4'd4, K_ACQ = 4'd5, K_REL = 4'd6, K_XUNK = 4'd7,
                           K_ERR = 4'd8, K_SID = 4'd9, K_AID = 4'd10;
    localparam int NV = 42;
    // {word, kind, a, b}; for writes a = {class, offset}
    localparam logic [99:0] VECS [0:NV-1] = '{
        {32'h00101545, K_NONE, 32'h0, 32'h0},          // R2 class 055 mask bits 0,2
        {32'hAAAA0001, K_WR,   32'h15400010, 32'hAAAA0001},
        {32'hAAAA0002, K_WR,   32'h15400012, 32'hAAAA0002},
        {32'h11000003, K_NONE, 32'h0, 32'h0},          // R3 incr x3
        {32'hB0000001, K_WR,   32'h15400100, 32'hB0000001},
        {32'hB0000002, K_WR,   32'h15400101, 32'hB0000002},
        {32'hB0000003, K_WR,   32'h15400102, 32'hB0000003},
        {32'h20200002, K_NONE, 32'h0, 32'h0},          // R4 fixed x2
        {32'hC0000001, K_WR,   32'h15400020, 32'hC0000001},
        {32'hC0000002, K_WR,   32'h15400020, 32'hC0000002},
        {32'h30408011, K_NONE, 32'h0, 32'h0},          // R5 mask bits 0,4,15
        {32'hD0000001, K_WR,   32'h15400040, 32'hD0000001},
        {32'hD0000002, K_WR,   32'h15400044, 32'hD0000002},
        {32'hD0000003, K_WR,   32'h1540004F, 32'hD0000003},
        {32'h12000000, K_NONE, 32'h0, 32'h0},          // R3 zero count
        {32'h4123BEEF, K_IMM,  32'h123, 32'hBEEF},
        {32'h50123456, K_RST,  32'h01234560, 32'h0},
        {32'h60AB8012, K_NONE, 32'h0, 32'h0},          // R8 gather header
        {32'h80001000, K_GTH,  32'h01568012, 32'h80001000},
        {32'hA0000010, K_NONE, 32'h0, 32'h0},          // R9 payload invalid
        {32'h8000005A, K_AID,  32'h5A, 32'h0},
        {32'h70123456, K_SID,  32'h123456, 32'h0},
        {32'h90000000, K_NONE, 32'h0, 32'h0},          // R9 payload zero
        {32'hB0000200, K_NONE, 32'h0, 32'h0},
        {32'h90000002, K_NONE, 32'h0, 32'h0},          // R9 payload two
        {32'hA02ABCDE, K_NONE, 32'h0, 32'h0},
        {32'h00000011, K_WR,   32'h156ABCDE, 32'h00000011},
        {32'h00000022, K_WR,   32'h156ABCDF, 32'h00000022},
        {32'hB0000300, K_NONE, 32'h0, 32'h0},          // R9 payload kept
        {32'h00000033, K_WR,   32'h15400300, 32'h00000033},
        {32'h00000044, K_WR,   32'h15400300, 32'h00000044},
        {32'hE0000007, K_ACQ,  32'h07, 32'h0},
        {32'hE1000033, K_REL,  32'h33, 32'h0},
        {32'hE5000000, K_XUNK, 32'h0, 32'h0},
        {32'hD0000000, K_ERR,  32'h0, 32'h0},
        {32'hF0000000, K_ERR,  32'h0, 32'h0},
        {32'hC0000155, K_NONE, 32'h0, 32'h0},          // R8 wide gather
        {32'h11112222, K_NONE, 32'h0, 32'h0},
        {32'h00000003, K_GTH,  32'h00010155, 32'h11112222},
        {32'h0000FFC0, K_NONE, 32'h0, 32'h0},          // R2 zero mask, class 3FF
        {32'h10050001, K_NONE, 32'h0, 32'h0},
        {32'h00000077, K_WR,   32'hFFC00005, 32'h00000077}
    };

    function automatic string tag_of(input logic [3:0] k);
        case (k)
            K_WR:   return "R3";
            K_IMM:  return "R6";
            K_RST:  return "R7";
            K_GTH:  return "R8";
            K_ACQ, K_REL, K_XUNK: return "R10";
            K_ERR:  return "R12";
            K_SID, K_AID: return "R11";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [6:0]  flags, eflags;
        logic [31:0] act;
        bit          fld;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(in_ready && !wr_valid && stream_id == 0 && app_id == 0, "R1",
              {in_ready, wr_valid, stream_id}, {1'b1, 1'b0, 22'h0});

        for (int i = 0; i < NV; i++) begin
            logic [31:0] w, a, b;
            logic [3:0]  k;
            {w, k, a, b} = VECS[i];
            send_word(w);
            flags = {imm_valid, restart_valid, gather_valid, lock_acq, lock_rel,
                     ext_unknown, op_err};
            case (k)
                K_IMM:  eflags = 7'b1000000;
                K_RST:  eflags = 7'b0100000;
                K_GTH:  eflags = 7'b0010000;
                K_ACQ:  eflags = 7'b0001000;
                K_REL:  eflags = 7'b0000100;
                K_XUNK: eflags = 7'b0000010;
                K_ERR:  eflags = 7'b0000001;
                default: eflags = 7'b0;
            endcase
            fld = 1'b1;
            act = '0;
            case (k)
                K_WR: begin
                    act = {wr_class, wr_offset};
                    fld = (act == a) && (wr_data == b);
                end
                K_IMM: begin
                    act = {4'h0, imm_offset, imm_data};
                    fld = (imm_offset == a[11:0]) && (imm_data == b[15:0]);
                end
                K_RST: begin
                    act = restart_addr;
                    fld = (act == a);
                end
                K_GTH: begin
                    act = {3'b0, gather_offset, gather_wide, gather_insert, gather_type,
                           gather_count};
                    fld = (act == a) && (gather_addr[31:0] == b);
                end
                K_ACQ, K_REL: begin
                    act = {24'h0, lock_index};
                    fld = (lock_index == a[7:0]);
                end
                K_SID: begin
                    act = {10'h0, stream_id};
                    fld = (act == a);
                end
                K_AID: begin
                    act = {24'h0, app_id};
                    fld = (act == a);
                end
                default: ;
            endcase
            check((flags == eflags) && (wr_valid == (k == K_WR)) && fld, tag_of(k),
                  {wr_valid, flags, act}, {(k == K_WR), eflags, a});
        end

        // R8 upper address half of the wide gather
        check(gather_addr[63:32] == 32'h3, "R8", gather_addr, 64'h3_11112222);

        // R1 payload invalid again after reset
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(stream_id == 0 && app_id == 0 && !wr_valid, "R1",
              {stream_id, app_id}, 64'h0);
        send_word(32'hA0000005);
        send_word(32'h40010002);
        check(imm_valid && imm_offset == 12'h1 && imm_data == 16'h2 && !wr_valid, "R1",
              {imm_valid, imm_offset, imm_data}, {1'b1, 12'h1, 16'h2});

        // R13 stall
        @(negedge clk);
        wr_ready = 1'b0;
        send_word(32'h10000002);
        send_word(32'h00000011);
        @(negedge clk);
        in_word = 32'h00000022;
        repeat (3) @(posedge clk);
        #2;
        check(wr_valid && !in_ready && wr_data == 32'h11 && wr_offset == 22'h0, "R13",
              {in_ready, wr_data}, {1'b0, 32'h11});
        @(negedge clk);
        wr_ready = 1'b1;
        @(posedge clk);
        #2;
        check(wr_valid && wr_data == 32'h22 && wr_offset == 22'h1, "R13",
              {wr_offset, wr_data}, {22'h1, 32'h22});
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        check(!wr_valid && in_ready, "R13", {wr_valid, in_ready}, {1'b0, 1'b1});

        finish_run();
    end
endmodule